// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing side of a 256-byte serial EEPROM. It runs on a fast system clock and samples the two-wire clock and data lines as ordinary synchronous inputs. It recognises the bus start and stop conditions and decodes an 8-bit device selector. The selector carries one of two 4-bit prefixes: one opens the memory array for reads and writes, the other programs a write-lock flag. Three selector bits must equal the strap pins, and the last bit gives the transfer direction. The block answers by pulling the data line low through an active-low open-drain enable.

A write transfer sets the byte pointer and then loads data bytes into a 16-entry staging buffer. Nothing reaches the array until a stop condition arrives. The stop condition starts a busy period. During that period the buffered bytes are copied into the array, and the block refuses to acknowledge its selector. A read transfer streams bytes from the pointer for as long as the master acknowledges each one. The pointer advances after every byte and wraps from the top of the array to address zero. Once the lock flag is set, writes aimed at the upper half of the array are still acknowledged but are discarded.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the data-line enable `sda_low_n_o` is 1 (line released), the write-lock flag is clear, and the data line is never pulled low while the slave is idle.
- R2: A start condition is a falling data line while the clock is high, and a stop condition is a rising data line while the clock is high. Bytes clocked before any start condition are not acknowledged.
- R3: A selector byte is sent MSB first. It is acknowledged (data line low during the 9th clock) only if bits 7:4 are 4'b1010 (memory access) or 4'b0110 with bit 0 = 0 (lock programming), and bits 3:1 equal `strap_i`. Any other selector is not acknowledged, and the slave stays idle until the next start.
- R4: After an acknowledged memory selector with bit 0 = 0 (write), the byte-address byte and every data byte that follows are acknowledged.
- R5: Written bytes reach the array only when a stop condition ends the write. Bytes whose write is cut off by a repeated start are discarded.
- R6: Selector bit 0 = 1 starts a read at the current pointer. Each byte is sent MSB first, with a 1 sent by releasing the line. The pointer advances by one after every byte read or written and wraps from 0xFF to 0x00.
- R7: A master NoACK (line high on the 9th clock) ends the read. The slave then keeps the line released for all later clocks until the next start.
- R8: After a stop condition that ends a write, the slave does not acknowledge any selector for BUSY_CYCLES system clocks. A start condition during that time does not disturb the bytes being committed.
- R9: An acknowledged lock-programming write, once ended by a stop, sets the lock flag. While the flag is set, data bytes addressed to 0x80..0xFF are acknowledged but not stored, and lower addresses are still stored.
- R10: Only the first PAGE (16) data bytes of one write are stored. Later bytes are acknowledged and dropped.
- R11: A repeated start in the middle of a transfer aborts it and restarts selector reception. The pointer loaded before the repeated start is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| strap_i | input | 3 | Chip-select straps compared with selector bits 3:1 |
| sda_low_n_o | output | 1 | Open-drain enable; 0 pulls the data line low |

## Verification
Two functions can act in the same cycles: the copy of staged bytes into the array after a stop, and the handling of a new start condition, which clears the staging buffer and restarts selector reception. The bench provokes this overlap by issuing a start and a selector right after the stop of a write. It checks that this selector is refused while the busy period runs. After the busy period it reads the written byte back and checks that the copy into the array was not cut short. A second overlap is a repeated start that lands while a write still has bytes in the staging buffer. The bench judges this case by reading back the old value at that address.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_WADR, S_WDAT, S_ACK, S_RDAT, S_RACK, S_HOLD
  } slv_state_t;

  localparam logic [3:0] PRE_MEM  = 4'b1010;
  localparam logic [3:0] PRE_LOCK = 4'b0110;
endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_sy[1];
      sda_p  <= sda_sy[1];
    end
  end

  assign sda_o      = sda_sy[1];
  assign scl_rise_o = scl_sy[1] & ~scl_p;
  assign scl_fall_o = ~scl_sy[1] & scl_p;
  // data edges qualify only when the clock was high on both samples
  assign start_o    = scl_sy[1] & scl_p & sda_p & ~sda_sy[1];
  assign stop_o     = scl_sy[1] & scl_p & ~sda_p & sda_sy[1];
endmodule

// File: rtl/i2c_wr_timer.sv
module i2c_wr_timer #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int TW = $clog2(BUSY_CYCLES + 1);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)            cnt_d = TW'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eeprom_page_store.sv
module eeprom_page_store #(
  parameter int MEM_AW = 8,
  parameter int PAGE   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_we_i,
  input  logic [MEM_AW-1:0] stage_addr_i,
  input  logic [7:0]        stage_data_i,
  input  logic              clr_i,
  input  logic              commit_i,
  input  logic              busy_i,
  input  logic [MEM_AW-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int NW    = $clog2(PAGE + 1);
  localparam int IW    = $clog2(PAGE);

  logic [7:0]        mem   [DEPTH];
  logic [MEM_AW-1:0] buf_a [PAGE];
  logic [7:0]        buf_d [PAGE];
  logic [NW-1:0]     n_q, n_d;
  logic [IW-1:0]     ci_q, ci_d;
  logic              cm_q, cm_d;
  logic              take;

  assign take = stage_we_i && (n_q < NW'(PAGE));

  always_comb begin
    n_d  = n_q;
    ci_d = ci_q;
    cm_d = cm_q;
    if (cm_q) begin
      ci_d = ci_q + 1'b1;
      if (NW'(ci_q) + 1'b1 == n_q) begin
        cm_d = 1'b0;
        n_d  = '0;
      end
    end else if (commit_i) begin
      cm_d = (n_q != '0);
      ci_d = '0;
    end else if (clr_i) begin
      n_d = '0;
    end else if (take) begin
      n_d = n_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q  <= '0;
      ci_q <= '0;
      cm_q <= 1'b0;
    end else begin
      n_q  <= n_d;
      ci_q <= ci_d;
      cm_q <= cm_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !cm_q && !clr_i && !commit_i) begin
      buf_a[n_q[IW-1:0]] <= stage_addr_i;
      buf_d[n_q[IW-1:0]] <= stage_data_i;
    end
    if (cm_q) mem[buf_a[ci_q]] <= buf_d[ci_q];
  end

  assign rdata_o = mem[raddr_i];

  // R8: the array copy runs entirely inside the busy window
  p_commit_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cm_q |-> busy_i);
  // R10: staging never holds more than one page
  p_page_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= NW'(PAGE));
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eeprom_pkg::*;
#(
  parameter int MEM_AW      = 8,
  parameter int PAGE        = 16,
  parameter int BUSY_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_low_n_o
);
  logic [1:0] rs_q;
  logic       rst_s;
  logic       scl_rise, scl_fall, sda_bit, bstart, bstop;
  logic       busy, stage_we, buf_clr, commit;
  logic [7:0] rdata;

  slv_state_t        st_q, st_d, nx_q, nx_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic [MEM_AW-1:0] ptr_q, ptr_d;
  logic              drv_q, drv_d, pend_q, pend_d, lkp_q, lkp_d;
  logic              lock_q, lock_d, rack_q, rack_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  i2c_line_watch u_line (
    .clk(clk), .rst_n(rst_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .sda_o(sda_bit),
    .start_o(bstart), .stop_o(bstop)
  );

  i2c_wr_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_s), .start_i(commit), .busy_o(busy)
  );

  eeprom_page_store #(.MEM_AW(MEM_AW), .PAGE(PAGE)) u_store (
    .clk(clk), .rst_n(rst_s), .stage_we_i(stage_we), .stage_addr_i(ptr_q),
    .stage_data_i(sh_q), .clr_i(buf_clr), .commit_i(commit), .busy_i(busy),
    .raddr_i(ptr_q), .rdata_o(rdata)
  );

  always_comb begin
    st_d = st_q;  nx_d = nx_q;  cnt_d = cnt_q;  sh_d = sh_q;
    ptr_d = ptr_q;  drv_d = drv_q;  pend_d = pend_q;  lkp_d = lkp_q;
    lock_d = lock_q;  rack_d = rack_q;
    stage_we = 1'b0;  buf_clr = 1'b0;  commit = 1'b0;
    if (bstart) begin
      st_d = S_DEV;  cnt_d = '0;  drv_d = 1'b0;
      pend_d = 1'b0;  lkp_d = 1'b0;  buf_clr = 1'b1;
    end else if (bstop) begin
      st_d = S_IDLE;  drv_d = 1'b0;
      commit = pend_q | lkp_q;
      if (lkp_q) lock_d = 1'b1;
      pend_d = 1'b0;  lkp_d = 1'b0;
    end else begin
      unique case (st_q)
        S_DEV, S_WADR, S_WDAT: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_bit};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = '0;
            st_d  = S_ACK;
            drv_d = 1'b1;
            if (st_q == S_DEV) begin
              if (sh_q[3:1] != strap_i || busy) begin
                st_d = S_IDLE;  drv_d = 1'b0;
              end else if (sh_q[7:4] == PRE_MEM) begin
                nx_d = sh_q[0] ? S_RDAT : S_WADR;
              end else if (sh_q[7:4] == PRE_LOCK && !sh_q[0]) begin
                nx_d = S_HOLD;  lkp_d = 1'b1;
              end else begin
                st_d = S_IDLE;  drv_d = 1'b0;
              end
            end else if (st_q == S_WADR) begin
              ptr_d = sh_q[MEM_AW-1:0];
              nx_d  = S_WDAT;
            end else begin
              stage_we = !(lock_q && ptr_q[MEM_AW-1]);
              pend_d   = 1'b1;
              ptr_d    = ptr_q + 1'b1;
              nx_d     = S_WDAT;
            end
          end
        end
        S_ACK: if (scl_fall) begin
          st_d = nx_q;  cnt_d = '0;  drv_d = 1'b0;
          if (nx_q == S_RDAT) begin
            sh_d = rdata;  drv_d = ~rdata[7];  cnt_d = 4'd1;
          end
        end
        S_RDAT: if (scl_fall) begin
          if (cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], 1'b0};
            drv_d = ~sh_q[6];
            cnt_d = cnt_q + 1'b1;
          end else begin
            drv_d = 1'b0;  ptr_d = ptr_q + 1'b1;  st_d = S_RACK;
          end
        end
        S_RACK: begin
          if (scl_rise) rack_d = ~sda_bit;
          if (scl_fall) begin
            if (rack_q) begin
              st_d = S_RDAT;  sh_d = rdata;  drv_d = ~rdata[7];  cnt_d = 4'd1;
            end else begin
              st_d = S_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= S_IDLE;  nx_q <= S_IDLE;  cnt_q <= '0;  sh_q <= '0;
      ptr_q <= '0;  drv_q <= 1'b0;  pend_q <= 1'b0;  lkp_q <= 1'b0;
      lock_q <= 1'b0;  rack_q <= 1'b0;
    end else begin
      st_q <= st_d;  nx_q <= nx_d;  cnt_q <= cnt_d;  sh_q <= sh_d;
      ptr_q <= ptr_d;  drv_q <= drv_d;  pend_q <= pend_d;  lkp_q <= lkp_d;
      lock_q <= lock_d;  rack_q <= rack_d;
    end
  end

  assign sda_low_n_o = ~drv_q;

  // R1: an idle slave leaves the line alone
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_IDLE) |-> !drv_q);
  // R7: the master owns the line while its acknowledge is sampled
  p_rack_released_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_RACK) |-> !drv_q);
  // R8: a selector ending during the busy window is refused
  p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_DEV && cnt_q == 4'd8 && scl_fall && busy) |=> !drv_q);
  // R9: the lock flag never clears once set
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_s)
    lock_q |=> lock_q);
  // R11: a start always restarts selector reception
  p_start_restarts_r11: assert property (@(posedge clk) disable iff (!rst_s)
    bstart |=> (st_q == S_DEV && cnt_q == 4'd0 && !drv_q));
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 10;
  localparam int BUSY       = 400;
  localparam logic [7:0] DEV_W  = 8'hAA;
  localparam logic [7:0] DEV_R  = 8'hAB;
  localparam logic [7:0] LOCK_W = 8'h6A;

  logic clk, rst_n, m_scl, m_sda, sda_low_n, sda_line;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];
  int total, bad;
  bit done;

  assign sda_line = m_sda & sda_low_n;

  i2c_eeprom_slave #(.MEM_AW(8), .PAGE(16), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(3'b101), .sda_low_n_o(sda_low_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_start();
    m_sda = 1'b1; tick(H/2); m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(H/2);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; tick(H/2); m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic m_bit(input logic b, output logic seen);
    m_sda = b; tick(H/2); m_scl = 1'b1; tick(H/2);
    seen = sda_line; tick(H/2); m_scl = 1'b0; tick(H/2);
  endtask

  task automatic m_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(b[i], s);
    m_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic m_read(input logic ackit, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, s); b[i] = s; end
    m_bit(~ackit, s);
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input string req);
    logic ack;
    m_start();
    m_byte(DEV_W, ack); chk({req, " R3 selector ack"}, ack, 1);
    m_byte(a, ack);     chk({req, " R4 address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      m_byte(wbuf[i], ack); chk({req, " R4 data ack"}, ack, 1);
    end
    m_stop();
    tick(BUSY + 100);
  endtask

  task automatic do_read(input logic [7:0] a, input int n);
    logic ack;
    m_start();
    m_byte(DEV_W, ack);
    m_byte(a, ack);
    m_start();
    m_byte(DEV_R, ack); chk("R6 read selector ack", ack, 1);
    for (int i = 0; i < n; i++) m_read(i < n - 1, rbuf[i]);
  endtask

  task automatic t_reset();
    chk("R1 line released after reset", sda_low_n, 1);
  endtask

  task automatic t_no_start();
    logic ack;
    m_scl = 1'b0; tick(H);
    m_byte(DEV_W, ack);
    chk("R2 no ack before start", ack, 0);
    m_scl = 1'b1; tick(H);
  endtask

  task automatic t_selector();
    logic ack;
    m_start(); m_byte(8'hA2, ack); chk("R3 strap mismatch nack", ack, 0); m_stop();
    m_start(); m_byte(8'hCA, ack); chk("R3 bad prefix nack", ack, 0); m_stop();
    m_start(); m_byte(8'h6B, ack); chk("R3 lock read nack", ack, 0); m_stop();
    m_start(); m_byte(DEV_W, ack); chk("R3 good selector ack", ack, 1); m_stop();
  endtask

  task automatic t_write_read();
    logic s;
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h11 + 8'(i);
    do_write(8'h20, 4, "wr4");
    do_read(8'h20, 4);
    for (int i = 0; i < 4; i++) chk("R6 sequential read", rbuf[i], 8'h11 + i);
    for (int i = 0; i < 9; i++) begin
      m_bit(1'b1, s); chk("R7 released after nack", s, 1);
    end
    m_stop();
  endtask

  task automatic t_busy();
    logic ack;
    m_start(); m_byte(DEV_W, ack); m_byte(8'h40, ack); m_byte(8'h5A, ack);
    m_stop();
    m_start(); m_byte(DEV_W, ack);
    chk("R8 selector refused while busy", ack, 0);
    m_stop();
    tick(BUSY + 100);
    do_read(8'h40, 1); m_stop();
    chk("R8 commit survives start", rbuf[0], 8'h5A);
  endtask

  task automatic t_abort();
    logic ack;
    wbuf[0] = 8'h77;
    do_write(8'h60, 1, "pre");
    m_start(); m_byte(DEV_W, ack); m_byte(8'h60, ack); m_byte(8'h99, ack);
    m_start(); m_byte(DEV_W, ack);
    chk("R11 repeated start re-selects", ack, 1);
    m_byte(8'h60, ack);
    m_start(); m_byte(DEV_R, ack);
    m_read(1'b0, rbuf[0]);
    m_stop();
    chk("R5 aborted write discarded", rbuf[0], 8'h77);
    m_start(); m_byte(DEV_W, ack); m_byte(8'h61, ack);
    m_start(); m_byte(DEV_R, ack);
    chk("R11 no busy after aborted write", ack, 1);
    m_read(1'b0, rbuf[0]); m_stop();
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    do_write(8'hFE, 3, "wrap");
    do_read(8'hFE, 3); m_stop();
    chk("R6 wrap byte FE", rbuf[0], 8'hA1);
    chk("R6 wrap byte FF", rbuf[1], 8'hA2);
    chk("R6 wrap byte 00", rbuf[2], 8'hA3);
  endtask

  task automatic t_page();
    wbuf[0] = 8'hEE; wbuf[1] = 8'hEF;
    do_write(8'h90, 2, "pre");
    for (int i = 0; i < 18; i++) wbuf[i] = 8'h30 + 8'(i);
    do_write(8'h80, 18, "page");
    do_read(8'h80, 18); m_stop();
    for (int i = 0; i < 16; i++) chk("R10 page bytes stored", rbuf[i], 8'h30 + i);
    chk("R10 byte 17 dropped", rbuf[16], 8'hEE);
    chk("R10 byte 18 dropped", rbuf[17], 8'hEF);
  endtask

  task automatic t_lock();
    logic ack;
    m_start(); m_byte(LOCK_W, ack); chk("R9 lock selector ack", ack, 1); m_stop();
    tick(BUSY + 100);
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    do_write(8'h7F, 2, "R9 locked");
    do_read(8'h7F, 2); m_stop();
    chk("R9 lower half stored", rbuf[0], 8'h01);
    chk("R9 upper half kept", rbuf[1], 8'h30);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    tick(5);
    chk("R1 line released in reset", sda_low_n, 1);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_no_start();
    t_selector();
    t_write_read();
    t_busy();
    t_abort();
    t_wrap();
    t_page();
    t_lock();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule